// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core with Output Feedback

The core encrypts one 128-bit block under a 128-bit key by running a single round of hardware over and over. That round holds sixteen substitution boxes, the row rotation, the column mixing and the round-key XOR. The key schedule advances one step per cycle next to the data, so round keys are never stored. The edge that accepts a start performs only the whitening XOR. The next ten edges each perform one full round, except that the last one skips the column mixing.

A small chaining wrapper provides output feedback mode. A feedback register is seeded with an initialisation vector. In feedback mode the core encrypts that register instead of the data input, writes the keystream block back into it, and returns the keystream XORed with the data word captured at start. Successive feedback-mode starts therefore produce a running keystream. In direct mode the core returns the plain ciphertext and leaves the feedback register untouched.

Byte order follows the usual convention: bits [127:120] of a 128-bit word are byte 0, and bytes fill the state column by column.

Top module: `aes128_iter_ofb`

## Requirements
- R1: After reset, busy_o, done_o and result_o are all zero.
- R2: With ofb_i low at start, result_o is the AES-128 ciphertext of data_i under key_i, with byte 0 at bits [127:120].
- R3: If start_i is sampled high on an idle edge n, busy_o is high after edges n through n+9, and done_o is high after edge n+10 with busy_o low.
- R4: start_i is ignored while busy_o is high. A second start during a run changes neither the result nor the completion cycle.
- R5: done_o is a single-cycle pulse. result_o holds its value until the next completion.
- R6: iv_load_i, taken on an idle edge with start_i low, loads the feedback register from data_i.
- R7: With ofb_i high at start, the keystream block is the encryption of the feedback register under key_i. result_o is that keystream XOR the data_i captured at start, and the keystream replaces the feedback register.
- R8: A direct-mode encryption leaves the feedback register unchanged.
- R9: iv_load_i has no effect while busy_o is high, or on an edge where start_i is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an encryption when idle |
| ofb_i | input | 1 | Mode for this start: 1 = output feedback, 0 = direct |
| iv_load_i | input | 1 | Load the feedback register from data_i |
| key_i | input | 128 | Cipher key, sampled at start |
| data_i | input | 128 | Plaintext or feedback-mode data, or IV when loading |
| busy_o | output | 1 | Encryption in progress |
| done_o | output | 1 | One-cycle pulse: result_o updated |
| result_o | output | 128 | Ciphertext or feedback-mode output |

## Verification
The hardest situations to reach are the internal ones. One is a start or IV load arriving mid-run. Another is the feedback register surviving a direct-mode block placed between feedback blocks. Neither shows up directly at the ports.

The stimulus raises start_i, with different key, data and mode, and iv_load_i throughout the busy window of selected runs. It then places a direct-mode block between an IV load and a feedback chain. Any corruption of the feedback register would then appear as a wrong keystream in the first chained output.

// File: rtl/aes_pkg.sv
package aes_pkg;
  localparam int unsigned BLK_W   = 128;
  localparam int unsigned NBYTES  = BLK_W / 8;
  localparam int unsigned NCOLS   = NBYTES / 4;
  localparam int unsigned NROUNDS = 10;
  localparam logic [7:0]  AFF_C   = 8'h63;
  localparam logic [7:0]  RCON0   = 8'h01;

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, x;
    acc = '0;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // inverse as x^254 = product of x^2 .. x^128; zero maps to zero
  function automatic logic [7:0] ginv(input logic [7:0] x);
    logic [7:0] r, sq;
    r  = 8'h01;
    sq = gmul(x, x);
    for (int i = 0; i < 7; i++) begin
      r  = gmul(r, sq);
      sq = gmul(sq, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    logic [7:0] r;
    r = b;
    for (int i = 0; i < n; i++) r = {r[6:0], r[7]};
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] b;
    b = ginv(x);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ AFF_C;
  endfunction
endpackage

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_pkg::*;
(
  input  logic [BLK_W-1:0] rkey_i,
  input  logic [7:0]       rcon_i,
  output logic [BLK_W-1:0] rkey_o
);
  logic [31:0] w [4];
  logic [31:0] nw [4];
  logic [31:0] rot, sub;

  for (genvar j = 0; j < 4; j++) begin : g_split
    assign w[j] = rkey_i[BLK_W-1-32*j -: 32];
    assign rkey_o[BLK_W-1-32*j -: 32] = nw[j];
  end

  assign rot = {w[3][23:0], w[3][31:24]};

  for (genvar b = 0; b < 4; b++) begin : g_sub
    assign sub[31-8*b -: 8] = sbox(rot[31-8*b -: 8]);
  end

  assign nw[0] = w[0] ^ sub ^ {rcon_i, 24'h0};
  for (genvar j = 1; j < 4; j++) begin : g_chain
    assign nw[j] = nw[j-1] ^ w[j];
  end
endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  input  logic             skip_mix_i,
  output logic [BLK_W-1:0] state_o
);
  logic [7:0] sb [NBYTES];
  logic [7:0] sr [NBYTES];
  logic [7:0] mc [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_sub
    assign sb[i] = sbox(state_i[BLK_W-1-8*i -: 8]);
  end

  // row r of column c takes row r of column (c + r) mod 4
  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign sr[4*c+r] = sb[4*((c+r)%NCOLS)+r];
    end
    for (genvar r = 0; r < 4; r++) begin : g_mix
      assign mc[4*c+r] = xtime(sr[4*c+r]) ^ xtime(sr[4*c+(r+1)%4]) ^ sr[4*c+(r+1)%4]
                       ^ sr[4*c+(r+2)%4] ^ sr[4*c+(r+3)%4];
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_out
    assign state_o[BLK_W-1-8*i -: 8] = (skip_mix_i ? sr[i] : mc[i]) ^ rkey_i[BLK_W-1-8*i -: 8];
  end
endmodule

// File: rtl/aes128_iter_ofb.sv
module aes128_iter_ofb
  import aes_pkg::*;
#(
  parameter int unsigned NR = NROUNDS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ofb_i,
  input  logic             iv_load_i,
  input  logic [BLK_W-1:0] key_i,
  input  logic [BLK_W-1:0] data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [BLK_W-1:0] result_o
);
  localparam int unsigned RW = $clog2(NR + 1);

  logic             busy_q, done_q, mode_q;
  logic [RW-1:0]    rnd_q;
  logic [7:0]       rcon_q;
  logic [BLK_W-1:0] state_q, rkey_q, data_q, fb_q, res_q;
  logic [BLK_W-1:0] nkey, nstate;
  logic             accept, last;

  assign accept = start_i & ~busy_q;
  assign last   = (rnd_q == RW'(NR));

  aes_key_step u_key (
    .rkey_i (rkey_q),
    .rcon_i (rcon_q),
    .rkey_o (nkey)
  );

  aes_round u_round (
    .state_i    (state_q),
    .rkey_i     (nkey),
    .skip_mix_i (last),
    .state_o    (nstate)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      mode_q  <= 1'b0;
      rnd_q   <= '0;
      rcon_q  <= '0;
      state_q <= '0;
      rkey_q  <= '0;
      data_q  <= '0;
      fb_q    <= '0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        // whitening only on the accepting edge
        state_q <= (ofb_i ? fb_q : data_i) ^ key_i;
        rkey_q  <= key_i;
        rcon_q  <= RCON0;
        rnd_q   <= RW'(1);
        busy_q  <= 1'b1;
        mode_q  <= ofb_i;
        data_q  <= data_i;
      end else if (busy_q) begin
        state_q <= nstate;
        rkey_q  <= nkey;
        rcon_q  <= xtime(rcon_q);
        rnd_q   <= rnd_q + RW'(1);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= mode_q ? (nstate ^ data_q) : nstate;
          if (mode_q) fb_q <= nstate;
        end
      end else if (iv_load_i) begin
        fb_q <= data_i;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o) && !busy_o); // R3
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !last) |=> busy_o && (rnd_q == $past(rnd_q) + RW'(1))); // R4
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o)); // R5
  AST_FB_KEPT_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mode_q) |=> $stable(fb_q)); // R8
  AST_IVLOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last) |=> $stable(fb_q)); // R9
  AST_RND_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rnd_q != '0) && (rnd_q <= RW'(NR))); // R3
endmodule

// File: tb/aes128_iter_ofb_bench.sv
module aes128_iter_ofb_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, ofb = 1'b0, iv_load = 1'b0;
  logic [127:0] key = '0, din = '0;
  logic         busy, done;
  logic [127:0] res;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] exp_t [256];
  logic [7:0] log_t [256];

  always #2 clk = ~clk;

  aes128_iter_ofb u_aes128_iter_ofb (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ofb_i(ofb), .iv_load_i(iv_load),
    .key_i(key), .data_i(din), .busy_o(busy), .done_o(done), .result_o(res)
  );

  function automatic logic [7:0] m2(input logic [7:0] b);
    return b[7] ? ((b << 1) ^ 8'h1b) : (b << 1);
  endfunction

  function automatic logic [7:0] ref_sb(input logic [7:0] x);
    logic [7:0] v, o;
    v = (x == 8'h00) ? 8'h00 : exp_t[(255 - int'(log_t[x])) % 255];
    for (int i = 0; i < 8; i++)
      o[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
    return o;
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] k0);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] k [16];
    logic [7:0] rc;
    logic [127:0] out;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) begin
      k[i] = k0[127-8*i -: 8];
      s[i] = pt[127-8*i -: 8] ^ k[i];
    end
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) t[i] = ref_sb(s[i]);
      for (int i = 0; i < 16; i++) s[i] = t[(i + 4*(i%4)) % 16];
      if (r != 10) begin
        for (int c = 0; c < 4; c++) begin
          logic [7:0] a0, a1, a2, a3;
          a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
          s[4*c]   = m2(a0) ^ m2(a1) ^ a1 ^ a2 ^ a3;
          s[4*c+1] = a0 ^ m2(a1) ^ m2(a2) ^ a2 ^ a3;
          s[4*c+2] = a0 ^ a1 ^ m2(a2) ^ m2(a3) ^ a3;
          s[4*c+3] = m2(a0) ^ a0 ^ a1 ^ a2 ^ m2(a3);
        end
      end
      k[0] = k[0] ^ ref_sb(k[13]) ^ rc;
      k[1] = k[1] ^ ref_sb(k[14]);
      k[2] = k[2] ^ ref_sb(k[15]);
      k[3] = k[3] ^ ref_sb(k[12]);
      for (int i = 4; i < 16; i++) k[i] = k[i] ^ k[i-4];
      rc = m2(rc);
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ k[i];
    end
    for (int i = 0; i < 16; i++) out[127-8*i -: 8] = s[i];
    return out;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  // one block; disturb=1 raises start/iv_load with other values during the run
  task automatic run(input logic m, input logic [127:0] k, input logic [127:0] d,
                     input logic disturb, output logic [127:0] r);
    logic [127:0] held;
    @(negedge clk);
    start = 1'b1; ofb = m; key = k; din = d; iv_load = disturb;
    @(posedge clk);
    @(negedge clk);
    chk("R3 busy after start", {127'b0, busy}, 128'd1);
    if (disturb) begin
      start = 1'b1; ofb = ~m; key = ~k; din = ~d; iv_load = 1'b1;
    end else begin
      start = 1'b0; iv_load = 1'b0;
    end
    repeat (9) @(posedge clk);
    @(negedge clk);
    chk("R3 no done before edge 10", {126'b0, busy, done}, 128'd2);
    start = 1'b0; iv_load = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R3 done at edge 10", {126'b0, busy, done}, 128'd1);
    r = res;
    held = res;
    @(negedge clk);
    chk("R5 done one cycle", {127'b0, done}, 128'd0);
    chk("R5 result held", res, held);
  endtask

  initial begin
    logic [127:0] r, k, d, iv, fb, ks;
    logic [7:0] e;
    void'($urandom(32'h5eed_a3e5));
    e = 8'h01;
    for (int i = 0; i < 255; i++) begin
      exp_t[i] = e;
      log_t[e] = 8'(i);
      e = e ^ m2(e);
    end
    exp_t[255] = 8'h01;
    log_t[0] = 8'h00;

    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {126'b0, busy, done}, 128'd0);
    chk("R1 reset result", res, 128'd0);
    rst_n = 1'b1;

    run(1'b0, 128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff, 1'b0, r);
    chk("R2 known-answer vector 1", r, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    run(1'b0, 128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734, 1'b1, r);
    chk("R4 vector 2 with start during run", r, 128'h3925841d02dc09fbdc118597196a0b32);
    run(1'b0, '0, '0, 1'b0, r);
    chk("R2 zero key zero data", r, ref_enc('0, '0));
    run(1'b0, '1, '1, 1'b1, r);
    chk("R4 all-ones with disturb", r, ref_enc('1, '1));

    for (int n = 0; n < 6; n++) begin
      k = {$urandom, $urandom, $urandom, $urandom};
      d = {$urandom, $urandom, $urandom, $urandom};
      run(1'b0, k, d, n[0], r);
      chk("R2 random direct", r, ref_enc(d, k));
    end

    // seed feedback register
    iv = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    iv_load = 1'b1; din = iv;
    @(negedge clk);
    iv_load = 1'b0;
    fb = iv;

    // direct block with disturbing iv loads: feedback must survive (R8, R9)
    k = {$urandom, $urandom, $urandom, $urandom};
    d = {$urandom, $urandom, $urandom, $urandom};
    run(1'b0, k, d, 1'b1, r);
    chk("R8 direct block result", r, ref_enc(d, k));

    k = {$urandom, $urandom, $urandom, $urandom};
    for (int n = 0; n < 4; n++) begin
      d = {$urandom, $urandom, $urandom, $urandom};
      run(1'b1, k, d, n == 2, r);
      ks = ref_enc(fb, k);
      chk(n == 0 ? "R6 R9 first block from loaded IV" : "R7 chained keystream", r, ks ^ d);
      fb = ks;
    end

    // reload IV and restart chain
    @(negedge clk);
    iv_load = 1'b1; din = iv;
    @(negedge clk);
    iv_load = 1'b0;
    d = '0;
    run(1'b1, k, d, 1'b0, r);
    chk("R6 reload IV restarts keystream", r, ref_enc(iv, k));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule